// File: doc/BRIEF.md
# Wake-Up Stabilization Timer Controller

This block decides how long the processor core and its peripherals hold off after an interrupt brings the device out of a deep low-power state (standby or watch), and which clock the core runs on once that hold-off ends. Software configures it through a single byte-wide control register. The register holds three fields:

- a 3-bit wait-length select;
- a low-speed flag that picks the subclock after leaving watch state;
- a 2-bit divider select for medium-speed operation.

When a wake request arrives in a low-power state, the block counts a power-of-two number of clock states. It then pulses a ready signal for one cycle. It also drives a clock-route output and a divider code, which feed an external prescaler.

The base wait length is a parameter, `BASE_SHIFT`. Its default of 13 gives waits of 8,192, 16,384, 32,768, 65,536 and 131,072 states. A smaller value shrinks every wait by the same factor, so that short test configurations are possible.

Top module: `wakeup_stab_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x04, and `waiting`, `ready`, `cpu_on_subclk` and `div_code` are all 0.
- R2: Register layout is bits 6:4 wait-length select, bit 3 low-speed flag and bits 1:0 divider select. Bit 2 always reads 1 and bit 7 always reads 0, and writes to either bit have no effect. A write in any mode updates bits 6:3.
- R3: A wait-length select of 0, 1, 2 or 3 gives a wait of 2^(BASE_SHIFT+code) states.
- R4: Any wait-length select with bit 2 set gives 2^(BASE_SHIFT+4) states, whatever its two low bits hold.
- R5: A wait starts when `wake_req` is sampled high while `pwr_mode` is standby (5) or watch (6). `waiting` is high from the next cycle for exactly L cycles. `ready` is high only in the last of them, and the counter then stops.
- R6: A wake request in any other mode (0–4, 7) starts no wait.
- R7: A wake request during a wait neither restarts nor extends it.
- R8: The wait length is taken from the register when the wait starts. A write to the select during a wait affects only later waits.
- R9: The divider select is written only when `pwr_mode` is high-speed active (0) or subactive (2). In every other mode that field keeps its value. `div_code` equals the field and `div_shift` equals 4 plus the field, giving division by 16, 32, 64 or 128.
- R10: When a wait starts from watch, `cpu_on_subclk` takes the low-speed flag. When it starts from standby, `cpu_on_subclk` becomes 0. The output holds its value between wait starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 3 | Current operating mode: 0 active high-speed, 1 active medium-speed, 2 subactive, 3 sleep high-speed, 4 sleep medium-speed, 5 standby, 6 watch, 7 unused |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| wake_req | input | 1 | Interrupt-driven wake request |
| rd_data | output | 8 | Control register read value |
| waiting | output | 1 | Stabilization wait in progress |
| ready | output | 1 | One-cycle pulse on the final wait cycle |
| cpu_on_subclk | output | 1 | 1 selects the subclock for the core after wake |
| div_code | output | 2 | Medium-speed divider select |
| div_shift | output | 3 | Log2 of the medium-speed division ratio |

## Verification
A register write is sampled at one edge, and its effect on `rd_data`, `div_code` and `div_shift` is checked at the falling edge that follows. A wake request is seen at edge E0. `cpu_on_subclk` and `waiting` change after E0. `ready` must appear on the L-th falling edge after E0, and `waiting` must be low on the falling edge after that. The bench checks `waiting` and `ready` on every falling edge of each wait against those cycle counts. It sweeps all eight wait-length codes, all 256 write values and every mode with a reduced `BASE_SHIFT`.

// File: rtl/wst_pkg.sv
package wst_pkg;

    typedef enum logic [2:0] {
        MODE_ACT_HS  = 3'd0,
        MODE_ACT_MS  = 3'd1,
        MODE_SUBACT  = 3'd2,
        MODE_SLP_HS  = 3'd3,
        MODE_SLP_MS  = 3'd4,
        MODE_STANDBY = 3'd5,
        MODE_WATCH   = 3'd6,
        MODE_UNUSED  = 3'd7
    } pmode_e;

    typedef struct packed {
        logic [2:0] wsel;
        logic       lspd;
        logic [1:0] msel;
    } ctrl_t;

    localparam int WSEL_LSB = 4;
    localparam int LSPD_BIT = 3;
    localparam int RSV_BIT  = 2;
    localparam int MSEL_LSB = 0;
    localparam int DIV_BASE_LOG2 = 4;

    // Exponent offset above the base: top select bit forces the longest wait.
    function automatic logic [2:0] wait_exp_off(input logic [2:0] wsel);
        return wsel[2] ? 3'd4 : {1'b0, wsel[1:0]};
    endfunction

    function automatic logic is_low_power(input pmode_e m);
        return (m == MODE_STANDBY) || (m == MODE_WATCH);
    endfunction

    function automatic logic msel_writable(input pmode_e m);
        return (m == MODE_ACT_HS) || (m == MODE_SUBACT);
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        logic [7:0] v;
        v = 8'h00;
        v[WSEL_LSB +: 3] = c.wsel;
        v[LSPD_BIT]      = c.lspd;
        v[RSV_BIT]       = 1'b1;
        v[MSEL_LSB +: 2] = c.msel;
        return v;
    endfunction

endpackage

// File: rtl/wst_ctrl_reg.sv
module wst_ctrl_reg
    import wst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl,
    output logic [7:0] rd_data
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.wsel <= wr_data[WSEL_LSB +: 3];
            ctrl_q.lspd <= wr_data[LSPD_BIT];
            if (msel_writable(mode)) begin
                ctrl_q.msel <= wr_data[MSEL_LSB +: 2];
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_data = pack_ctrl(ctrl_q);

    // R1: reset clears every field.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0));

    // R9: divider field is frozen outside the two permitted modes.
    a_r9_msel_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !msel_writable(mode)) |=> $stable(ctrl_q.msel));

    // R2: with no write, nothing in the register moves.
    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/wst_wait_timer.sv
module wst_wait_timer
    import wst_pkg::*;
#(
    parameter int BASE_SHIFT = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] wsel,
    output logic       busy,
    output logic       done
);

    localparam int CNT_W = BASE_SHIFT + 5;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_c;
    logic [2:0]       exp_q;
    logic             busy_q;
    logic [CNT_W-1:0] one_c;

    assign one_c  = {{(CNT_W-1){1'b0}}, 1'b1};
    assign last_c = (one_c << (BASE_SHIFT + 32'(exp_q))) - one_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            exp_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                exp_q  <= wait_exp_off(wsel);
            end
        end else if (cnt_q == last_c) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + one_c;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == last_c);

    // R5: ready lasts exactly one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: counter never passes the selected terminal value.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= last_c));

    // R8: the latched length holds for the whole wait.
    a_r8_len_latched: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> $stable(exp_q));

    // R4: the latched exponent never exceeds the longest setting.
    a_r4_exp_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (exp_q <= 3'd4));

endmodule

// File: rtl/wst_clk_route.sv
module wst_clk_route
    import wst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  pmode_e     mode,
    input  logic       lspd,
    input  logic [1:0] msel,
    output logic       cpu_sub,
    output logic [1:0] div_code,
    output logic [2:0] div_shift
);

    logic sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= 1'b0;
        end else if (start) begin
            sub_q <= (mode == MODE_WATCH) ? lspd : 1'b0;
        end
    end

    assign cpu_sub   = sub_q;
    assign div_code  = msel;
    assign div_shift = 3'(DIV_BASE_LOG2) + {1'b0, msel};

    // R10: leaving standby always selects the main clock.
    a_r10_standby_main: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_STANDBY) |=> !sub_q);

    // R10: the route holds between wait starts.
    a_r10_route_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(sub_q));

endmodule

// File: rtl/wakeup_stab_ctrl.sv
module wakeup_stab_ctrl
    import wst_pkg::*;
#(
    parameter int BASE_SHIFT = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pwr_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wake_req,
    output logic [7:0] rd_data,
    output logic       waiting,
    output logic       ready,
    output logic       cpu_on_subclk,
    output logic [1:0] div_code,
    output logic [2:0] div_shift
);

    pmode_e mode;
    ctrl_t  ctrl;
    logic   busy;
    logic   start;

    assign mode  = pmode_e'(pwr_mode);
    assign start = wake_req && is_low_power(mode) && !busy;

    wst_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    wst_wait_timer #(
        .BASE_SHIFT (BASE_SHIFT)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .wsel  (ctrl.wsel),
        .busy  (busy),
        .done  (ready)
    );

    wst_clk_route u_route (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .lspd      (ctrl.lspd),
        .msel      (ctrl.msel),
        .cpu_sub   (cpu_on_subclk),
        .div_code  (div_code),
        .div_shift (div_shift)
    );

    assign waiting = busy;

    // R6: outside standby and watch, an idle block stays idle.
    a_r6_no_start_awake: assert property (@(posedge clk) disable iff (rst)
        (!waiting && !is_low_power(mode)) |=> !waiting);

    // R7: a wait runs to its end regardless of further requests.
    a_r7_no_abort: assert property (@(posedge clk) disable iff (rst)
        (waiting && !ready) |=> waiting);

    // R5: a wait ends in the cycle after its ready pulse.
    a_r5_end_after_ready: assert property (@(posedge clk) disable iff (rst)
        ready |=> !waiting || $rose(waiting));

endmodule

// File: tb/wakeup_stab_ctrl_test.sv
module wakeup_stab_ctrl_test;

    localparam int BS = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pwr_mode = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wake_req = 1'b0;
    logic [7:0] rd_data;
    logic       waiting;
    logic       ready;
    logic       cpu_on_subclk;
    logic [1:0] div_code;
    logic [2:0] div_shift;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    wakeup_stab_ctrl #(.BASE_SHIFT(BS)) uut (
        .clk           (clk),
        .rst           (rst),
        .pwr_mode      (pwr_mode),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wake_req      (wake_req),
        .rd_data       (rd_data),
        .waiting       (waiting),
        .ready         (ready),
        .cpu_on_subclk (cpu_on_subclk),
        .div_code      (div_code),
        .div_shift     (div_shift)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input int mode);
        @(negedge clk);
        pwr_mode = 3'(mode);
        wr_en    = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected wait length for a select code.
    function automatic int wlen(input int code);
        return (code >= 4) ? (1 << (BS + 4)) : (1 << (BS + code));
    endfunction

    // Wake at edge E0, then check every falling edge for L+1 cycles.
    task automatic run_wait(input string req, input int mode, input int len,
                            input int wake_at, input int wr_at,
                            input logic [7:0] wr_val, input int exp_sub);
        int bad_k;
        bad_k = 0;
        @(negedge clk);
        pwr_mode = 3'(mode);
        wake_req = 1'b1;
        for (int k = 1; k <= len + 1; k++) begin
            @(negedge clk);
            if (bad_k == 0 && (int'(waiting) != int'(k <= len) ||
                               int'(ready) != int'(k == len)))
                bad_k = k;
            if (k == 1) chk({req, " subclk route"}, int'(cpu_on_subclk), exp_sub);
            wake_req = (k == wake_at);
            wr_en    = (k == wr_at);
            wr_data  = wr_val;
        end
        wake_req = 1'b0;
        wr_en    = 1'b0;
        chk({req, " wait timing (first bad cycle)"}, bad_k, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 rd_data", int'(rd_data), 8'h04);
        chk("R1 waiting", int'(waiting), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 subclk", int'(cpu_on_subclk), 0);
        chk("R1 div_code", int'(div_code), 0);

        // R2: full write sweep in high-speed active mode
        for (int d = 0; d < 256; d++) begin
            wr(8'(d), 0);
            chk("R2 readback", int'(rd_data), (d & 8'h7B) | 8'h04);
        end

        // R9: divider field per mode
        for (int m = 0; m < 8; m++) begin
            for (int v = 1; v < 4; v++) begin
                wr(8'h00, 0);
                wr(8'h70 | 8'(v), m);
                chk("R9 div_code", int'(div_code), (m == 0 || m == 2) ? v : 0);
                chk("R9 div_shift", int'(div_shift), (m == 0 || m == 2) ? 4 + v : 4);
                chk("R9 other fields written", int'(rd_data[7:2]), 8'h1D);
            end
        end

        // R3, R4: every wait-length code from standby
        for (int c = 0; c < 8; c++) begin
            wr(8'(c << 4), 0);
            run_wait((c < 4) ? "R3" : "R4", 5, wlen(c), 0, 0, 8'h00, 0);
        end

        // R6: no wait outside low-power modes
        wr(8'h00, 0);
        for (int m = 0; m < 8; m++) begin
            if (m == 5 || m == 6) continue;
            @(negedge clk);
            pwr_mode = 3'(m);
            wake_req = 1'b1;
            @(negedge clk);
            wake_req = 1'b0;
            chk("R6 no wait started", int'(waiting), 0);
            @(negedge clk);
            chk("R6 still idle", int'(waiting), 0);
        end

        // R7: extra wake mid-wait does not extend
        wr(8'h10, 0);
        run_wait("R7", 6, wlen(1), 3, 0, 8'h00, 0);
        run_wait("R7 last-cycle wake", 5, wlen(1), wlen(1), 0, 8'h00, 0);
        // the wake on the ready cycle must not retrigger
        chk("R7 no restart", int'(waiting), 0);

        // R8: select change mid-wait applies next time
        wr(8'h20, 0);
        run_wait("R8 old length", 5, wlen(2), 0, 2, 8'h00, 0);
        run_wait("R8 new length", 5, wlen(0), 0, 0, 8'h00, 0);

        // R10: clock route on wake
        wr(8'h08, 0);
        run_wait("R10 watch lspd=1", 6, wlen(0), 0, 0, 8'h00, 1);
        run_wait("R10 standby lspd=1", 5, wlen(0), 0, 0, 8'h00, 0);
        run_wait("R10 watch lspd=1 again", 6, wlen(0), 0, 0, 8'h00, 1);
        wr(8'h00, 0);
        chk("R10 route holds", int'(cpu_on_subclk), 1);
        run_wait("R10 watch lspd=0", 6, wlen(0), 0, 0, 8'h00, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule